// File: doc/BRIEF.md
# Half-Duplex Command Procedure Engine

This block is the reader-side controller for a half-duplex, character-oriented smart-card command exchange. A host starts a command by supplying a five-byte header, the direction of the data phase and a waiting-time index. The engine sends the header through a byte transmit handshake. It then listens for procedure bytes from the card and acts on each one. A procedure byte can ask the engine to keep waiting, to move all remaining data bytes, to move a single data byte, or to close the command with a two-byte status word.

Acknowledge bytes also choose whether the programming-voltage enable is on or off for the transfer that follows. The engine enforces a work waiting time on every character it expects from the card. It ends the command with a timeout code when that time runs out. Any procedure byte that cannot be used, or an acknowledge that would move more bytes than the header's length byte allows, ends the command with a protocol-error code. Character framing and parity recovery sit in a separate character layer below this block.

Top module: `hdx_cmd_engine`

## Requirements
- R1: A `cmd_start` pulse while idle sends the header on `tx_data` in the order `cmd_hdr[7:0]`, `[15:8]` (INS), `[23:16]`, `[31:24]`, `[39:32]` (length byte). Each byte keeps `tx_valid` high and `tx_data` stable until `tx_ready` is seen. After the fifth byte, the engine waits for a procedure byte.
- R2: A received procedure byte is classed in this priority order. 0x60 is null. Any other byte whose upper nibble is 6 or 9 is the first status byte. A byte equal to INS or INS^0x01 is an all-remaining acknowledge. A byte equal to ~INS or ~(INS^0x01) is a single-byte acknowledge. Every other byte is invalid.
- R3: A null byte leaves the engine waiting for another procedure byte and restarts the work waiting time from the cycle it arrives.
- R4: An all-remaining acknowledge moves every data byte still owed, out of the total given by the length byte. The engine then waits for a new procedure byte.
- R5: A single-byte acknowledge moves exactly one data byte. The engine then waits for a new procedure byte.
- R6: With `cmd_to_card`=1, each data byte is taken from `wr_data`, sent on `tx_data`, and marked by a one-cycle `wr_pop`. With `cmd_to_card`=0, each received data byte is passed out on `rd_data` with a one-cycle `rd_valid` in the cycle after it arrives.
- R7: `vpp_on` becomes 1 on the INS^0x01 and ~(INS^0x01) acknowledges and 0 on the INS and ~INS acknowledges. It holds until the next acknowledge and is 0 whenever the engine is idle.
- R8: After a first status byte, the next received byte is the second status byte. In the cycle after that byte arrives, `done` pulses for one cycle, `end_status`=1 (ok), and `card_sw1`/`card_sw2` hold the two bytes. `end_status` is 0 after reset.
- R9: The work waiting time is 960 x WI x `ETU_CLKS` cycles, where WI comes from `cmd_wi` and a value of 0 selects 10. If no card character arrives within that time, counting from the last card character or from the start of waiting, `done` pulses one cycle after the limit is reached and `end_status`=2 (timeout).
- R10: An acknowledge that arrives when no data bytes remain ends the command with `end_status`=3 (protocol error).
- R11: An invalid procedure byte ends the command with `end_status`=3.
- R12: Card characters that arrive while the engine is idle or sending the header have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (used only when idle) |
| cmd_hdr | input | 40 | Header bytes, first byte in bits 7:0, length byte in bits 39:32 |
| cmd_to_card | input | 1 | 1: data phase goes to the card, 0: from the card |
| cmd_wi | input | 8 | Waiting-time index, 0 selects the default |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| end_status | output | 2 | 0 none, 1 ok, 2 timeout, 3 protocol error |
| card_sw1 | output | 8 | First status byte |
| card_sw2 | output | 8 | Second status byte |
| tx_valid | output | 1 | Byte offered to the character layer |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Character layer accepts the byte |
| rx_valid | input | 1 | One-cycle strobe: byte received from the card |
| rx_data | input | 8 | Received byte |
| wr_data | input | 8 | Next outgoing data byte from the host |
| wr_pop | output | 1 | Host may advance `wr_data` |
| rd_valid | output | 1 | Incoming data byte strobe |
| rd_data | output | 8 | Incoming data byte |
| vpp_on | output | 1 | Programming-voltage enable |

## Verification
Every card byte is taken at one clock edge. Its result (`done`, `end_status`, status bytes, `vpp_on`, `rd_valid`/`rd_data`) is registered at that same edge. The bench therefore reads these outputs at the falling edge that directly follows the byte's one-cycle strobe. Transmitted bytes are logged at the edge where `tx_valid` and `tx_ready` meet, and counts are compared after the engine has had time to stop. For the timeout, the bench counts falling edges from the null byte and expects `done` after exactly 960·WI·`ETU_CLKS`+1 of them, for both an explicit WI and the default. A sweep of all 256 procedure-byte values checks each outcome against a class computed in the bench.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] NULL_BYTE = 8'h60;

  localparam logic [1:0] END_NONE    = 2'd0;
  localparam logic [1:0] END_OK      = 2'd1;
  localparam logic [1:0] END_TIMEOUT = 2'd2;
  localparam logic [1:0] END_PROTO   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PROC,
    ST_SEND,
    ST_RECV,
    ST_SW2
  } eng_state_t;

  typedef enum logic [2:0] {
    PB_NULL,
    PB_SW1,
    PB_ACK_ALL,
    PB_ACK_ONE,
    PB_BAD
  } pb_class_t;
endpackage

// File: rtl/hdx_pb_decode.sv
module hdx_pb_decode
  import hdx_pkg::*;
(
  input  logic [BYTE_W-1:0] ins,
  input  logic [BYTE_W-1:0] pbyte,
  output pb_class_t         pclass,
  output logic              vpp_req
);
  logic [BYTE_W-1:0] ins_alt;
  logic [3:0]        hi_nib;

  assign ins_alt = ins ^ {{(BYTE_W-1){1'b0}}, 1'b1};
  assign hi_nib  = pbyte[BYTE_W-1 -: 4];

  // Classification priority: null, status, all-remaining, single, invalid
  always_comb begin
    vpp_req = 1'b0;
    if (pbyte == NULL_BYTE) begin
      pclass = PB_NULL;
    end else if (hi_nib == 4'h6 || hi_nib == 4'h9) begin
      pclass = PB_SW1;
    end else if (pbyte == ins) begin
      pclass = PB_ACK_ALL;
    end else if (pbyte == ins_alt) begin
      pclass  = PB_ACK_ALL;
      vpp_req = 1'b1;
    end else if (pbyte == ~ins) begin
      pclass = PB_ACK_ONE;
    end else if (pbyte == ~ins_alt) begin
      pclass  = PB_ACK_ONE;
      vpp_req = 1'b1;
    end else begin
      pclass = PB_BAD;
    end
  end
endmodule

// File: rtl/hdx_wwt_timer.sv
module hdx_wwt_timer #(
  parameter int unsigned ETU_CLKS   = 372,
  parameter int unsigned WI_DEFAULT = 10,
  parameter int          WWT_W      = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clear,
  input  logic [7:0] wi,
  output logic       expired
);
  localparam int unsigned UNIT = 960 * ETU_CLKS;

  logic [7:0]       wi_eff;
  logic [WWT_W-1:0] limit;
  logic [WWT_W-1:0] cnt;

  assign wi_eff  = (wi == 8'd0) ? 8'(WI_DEFAULT) : wi;
  assign limit   = WWT_W'(wi_eff) * WWT_W'(UNIT);
  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || clear) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: expiry can only appear after the timer has been running
  assert_expiry_after_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(run));
endmodule

// File: rtl/hdx_xfer_count.sv
module hdx_xfer_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] remaining,
  output logic          is_zero,
  output logic          is_one
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (dec) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign is_zero = (remaining == '0);
  assign is_one  = (remaining == CW'(1));

  // R10: data moves never exceed the length byte
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);
  assert_no_load_during_move_R4: assert property (@(posedge clk) disable iff (rst)
    !(load && dec));
endmodule

// File: rtl/hdx_cmd_engine.sv
module hdx_cmd_engine
  import hdx_pkg::*;
#(
  parameter int unsigned ETU_CLKS   = 372,
  parameter int unsigned WI_DEFAULT = 10,
  parameter int          WWT_W      = 32,
  parameter int          HDR_BYTES  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_start,
  input  logic [HDR_BYTES*BYTE_W-1:0] cmd_hdr,
  input  logic                      cmd_to_card,
  input  logic [7:0]                cmd_wi,
  output logic                      busy,
  output logic                      done,
  output logic [1:0]                end_status,
  output logic [BYTE_W-1:0]         card_sw1,
  output logic [BYTE_W-1:0]         card_sw2,
  output logic                      tx_valid,
  output logic [BYTE_W-1:0]         tx_data,
  input  logic                      tx_ready,
  input  logic                      rx_valid,
  input  logic [BYTE_W-1:0]         rx_data,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic                      wr_pop,
  output logic                      rd_valid,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      vpp_on
);
  localparam int HDR_W   = HDR_BYTES * BYTE_W;
  localparam int IDX_W   = $clog2(HDR_BYTES);
  localparam int INS_POS = 1;
  localparam int LEN_POS = HDR_BYTES - 1;

  eng_state_t          state;
  logic [HDR_W-1:0]    hdr_q;
  logic [IDX_W-1:0]    byte_idx;
  logic                dir_q;
  logic                one_q;
  logic [7:0]          wi_q;
  logic [BYTE_W-1:0]   hdr_bytes [HDR_BYTES];

  generate
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr_unpack
      assign hdr_bytes[g] = hdr_q[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  // Procedure byte classification
  pb_class_t pclass;
  logic      vpp_req;

  hdx_pb_decode u_decode (
    .ins     (hdr_bytes[INS_POS]),
    .pbyte   (rx_data),
    .pclass  (pclass),
    .vpp_req (vpp_req)
  );

  // Work waiting time
  logic tmr_run;
  logic tmr_expired;

  assign tmr_run = (state == ST_PROC) || (state == ST_RECV) || (state == ST_SW2);

  hdx_wwt_timer #(
    .ETU_CLKS   (ETU_CLKS),
    .WI_DEFAULT (WI_DEFAULT),
    .WWT_W      (WWT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .clear   (rx_valid),
    .wi      (wi_q),
    .expired (tmr_expired)
  );

  // Data byte budget
  logic              cnt_load;
  logic              cnt_dec;
  logic [BYTE_W-1:0] cnt_rem;
  logic              cnt_zero;
  logic              cnt_one;
  logic              tx_fire;

  assign tx_fire  = tx_valid && tx_ready;
  assign cnt_load = (state == ST_IDLE) && cmd_start;
  assign cnt_dec  = ((state == ST_SEND) && tx_fire) ||
                    ((state == ST_RECV) && rx_valid);

  hdx_xfer_count #(.CW(BYTE_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load      (cnt_load),
    .load_val  (cmd_hdr[LEN_POS*BYTE_W +: BYTE_W]),
    .dec       (cnt_dec),
    .remaining (cnt_rem),
    .is_zero   (cnt_zero),
    .is_one    (cnt_one)
  );

  // Command termination decision
  logic       fin;
  logic [1:0] fin_code;

  always_comb begin
    fin      = 1'b0;
    fin_code = END_NONE;
    unique case (state)
      ST_PROC: begin
        if (rx_valid) begin
          if (pclass == PB_BAD) begin
            fin      = 1'b1;
            fin_code = END_PROTO;
          end else if ((pclass == PB_ACK_ALL || pclass == PB_ACK_ONE) && cnt_zero) begin
            fin      = 1'b1;
            fin_code = END_PROTO;
          end
        end else if (tmr_expired) begin
          fin      = 1'b1;
          fin_code = END_TIMEOUT;
        end
      end
      ST_SW2: begin
        if (rx_valid) begin
          fin      = 1'b1;
          fin_code = END_OK;
        end else if (tmr_expired) begin
          fin      = 1'b1;
          fin_code = END_TIMEOUT;
        end
      end
      ST_RECV: begin
        if (!rx_valid && tmr_expired) begin
          fin      = 1'b1;
          fin_code = END_TIMEOUT;
        end
      end
      default: ;
    endcase
  end

  // Main sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hdr_q      <= '0;
      byte_idx   <= '0;
      dir_q      <= 1'b0;
      one_q      <= 1'b0;
      wi_q       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      end_status <= END_NONE;
      card_sw1   <= '0;
      card_sw2   <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      wr_pop     <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      vpp_on     <= 1'b0;
    end else begin
      wr_pop   <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (fin) begin
        state      <= ST_IDLE;
        busy       <= 1'b0;
        done       <= 1'b1;
        end_status <= fin_code;
        vpp_on     <= 1'b0;
        tx_valid   <= 1'b0;
        if (state == ST_SW2 && rx_valid) begin
          card_sw2 <= rx_data;
        end
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (cmd_start) begin
              hdr_q      <= cmd_hdr;
              dir_q      <= cmd_to_card;
              wi_q       <= cmd_wi;
              byte_idx   <= '0;
              busy       <= 1'b1;
              end_status <= END_NONE;
              card_sw1   <= '0;
              card_sw2   <= '0;
              state      <= ST_HDR;
            end
          end
          ST_HDR: begin
            if (!tx_valid) begin
              tx_valid <= 1'b1;
              tx_data  <= hdr_bytes[byte_idx];
            end else if (tx_ready) begin
              tx_valid <= 1'b0;
              if (byte_idx == IDX_W'(HDR_BYTES - 1)) begin
                state <= ST_PROC;
              end else begin
                byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          ST_PROC: begin
            if (rx_valid) begin
              unique case (pclass)
                PB_SW1: begin
                  card_sw1 <= rx_data;
                  state    <= ST_SW2;
                end
                PB_ACK_ALL, PB_ACK_ONE: begin
                  one_q  <= (pclass == PB_ACK_ONE);
                  vpp_on <= vpp_req;
                  state  <= dir_q ? ST_SEND : ST_RECV;
                end
                default: ;
              endcase
            end
          end
          ST_SEND: begin
            if (!tx_valid) begin
              tx_valid <= 1'b1;
              tx_data  <= wr_data;
              wr_pop   <= 1'b1;
            end else if (tx_ready) begin
              tx_valid <= 1'b0;
              if (one_q || cnt_one) begin
                state <= ST_PROC;
              end
            end
          end
          ST_RECV: begin
            if (rx_valid) begin
              rd_valid <= 1'b1;
              rd_data  <= rx_data;
              if (one_q || cnt_one) begin
                state <= ST_PROC;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an offered byte stays put until accepted
  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R3: a null byte keeps the engine waiting
  assert_null_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROC) && rx_valid && (rx_data == NULL_BYTE) |=> (state == ST_PROC) && !done);
  // R6: host-side strobes follow the chosen direction
  assert_pop_dir_R6: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> dir_q);
  assert_rd_dir_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !dir_q);
  // R7: programming voltage off outside a command
  assert_vpp_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !vpp_on);
  // R8: end pulse is single and carries a code
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_code_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (end_status != END_NONE) && !busy);
  // R9: a timeout never ends a command in a cycle that carried a card byte
  assert_timeout_silent_R9: assert property (@(posedge clk) disable iff (rst)
    done && (end_status == END_TIMEOUT) |-> $past(!rx_valid));
  // R12: idle engine ignores card bytes
  assert_idle_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !cmd_start |=> (state == ST_IDLE));
endmodule

// File: tb/hdx_cmd_engine_tb.sv
module hdx_cmd_engine_tb;
  localparam int ETU = 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_start;
  logic [39:0] cmd_hdr;
  logic        cmd_to_card;
  logic [7:0]  cmd_wi;
  logic        busy, done;
  logic [1:0]  end_status;
  logic [7:0]  card_sw1, card_sw2;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic [7:0]  wr_data = 8'hA0;
  logic        wr_pop;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        vpp_on;

  always #10 clk = ~clk;

  hdx_cmd_engine #(.ETU_CLKS(ETU)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_hdr(cmd_hdr),
    .cmd_to_card(cmd_to_card), .cmd_wi(cmd_wi), .busy(busy), .done(done),
    .end_status(end_status), .card_sw1(card_sw1), .card_sw2(card_sw2),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .wr_data(wr_data), .wr_pop(wr_pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .vpp_on(vpp_on)
  );

  int tests = 0;
  int fails = 0;
  int tx_cnt = 0;
  int pops = 0;
  logic [7:0] tx_log [64];

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_log[tx_cnt % 64] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    if (wr_pop) begin
      pops    <= pops + 1;
      wr_data <= 8'hA0 + 8'(pops + 1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] ins, input logic [7:0] p3,
                           input bit to_card, input logic [7:0] wi);
    int base;
    base        = tx_cnt;
    cmd_hdr     = {p3, 8'h5A, 8'h3C, ins, 8'h00};
    cmd_to_card = to_card;
    cmd_wi      = wi;
    cmd_start   = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (tx_cnt < base + 5) @(negedge clk);
  endtask

  function automatic int exp_class(input logic [7:0] b, input logic [7:0] ins);
    if (b == 8'h60) return 0;
    if (b[7:4] == 4'h6 || b[7:4] == 4'h9) return 1;
    if (b == ins || b == (ins ^ 8'h01)) return 2;
    if (b == ~ins || b == ~(ins ^ 8'h01)) return 3;
    return 4;
  endfunction

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    int base;
    int pb;
    int k;
    rst = 1'b1; cmd_start = 1'b0; cmd_hdr = '0; cmd_to_card = 1'b0; cmd_wi = 8'd1;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R8 status 0, R7 vpp off)
    chk(!busy && !done && !tx_valid && !vpp_on && end_status == 2'd0, "R8 reset",
        {busy, done, tx_valid, vpp_on, end_status}, 0);

    // R12: card byte while idle
    send_rx(8'h90);
    @(negedge clk);
    chk(!done && !busy && end_status == 2'd0, "R12 idle rx", {busy, done, end_status}, 0);

    // R1 header order, R8 status end
    base = tx_cnt;
    start_cmd(8'hA4, 8'h02, 1'b0, 8'd1);
    chk(tx_log[(base+0)%64] == 8'h00, "R1 hdr byte0", tx_log[(base+0)%64], 8'h00);
    chk(tx_log[(base+1)%64] == 8'hA4, "R1 hdr byte1", tx_log[(base+1)%64], 8'hA4);
    chk(tx_log[(base+2)%64] == 8'h3C, "R1 hdr byte2", tx_log[(base+2)%64], 8'h3C);
    chk(tx_log[(base+3)%64] == 8'h5A, "R1 hdr byte3", tx_log[(base+3)%64], 8'h5A);
    chk(tx_log[(base+4)%64] == 8'h02, "R1 hdr byte4", tx_log[(base+4)%64], 8'h02);
    send_rx(8'h6A);
    chk(busy && !done, "R8 wait sw2", done, 0);
    send_rx(8'h82);
    chk(done && end_status == 2'd1 && card_sw1 == 8'h6A && card_sw2 == 8'h82, "R8 sw end",
        {end_status, card_sw1, card_sw2}, {2'd1, 8'h6A, 8'h82});

    // R12: card byte during header is ignored
    base = tx_cnt;
    cmd_hdr = {8'h00, 8'h5A, 8'h3C, 8'h70, 8'h00};
    cmd_to_card = 1'b0; cmd_wi = 8'd1;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    send_rx(8'h6F);
    while (tx_cnt < base + 5) @(negedge clk);
    send_rx(8'h91);
    chk(busy && !done, "R12 hdr rx ignored", {busy, done}, 2'b10);
    send_rx(8'h22);
    chk(done && card_sw1 == 8'h91 && card_sw2 == 8'h22, "R12 sw after hdr",
        {card_sw1, card_sw2}, {8'h91, 8'h22});

    // R4/R6: all-remaining, to card
    base = tx_cnt; pb = pops;
    start_cmd(8'h20, 8'h04, 1'b1, 8'd1);
    send_rx(8'h20);
    while (tx_cnt < base + 9) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(tx_cnt == base + 9 && pops == pb + 4, "R4 all count", tx_cnt - base, 9);
    for (int i = 0; i < 4; i++)
      chk(tx_log[(base+5+i)%64] == 8'hA0 + 8'(pb + i), "R6 out data",
          tx_log[(base+5+i)%64], 8'hA0 + 8'(pb + i));
    chk(busy && !done && !vpp_on, "R4 back to wait", {busy, done, vpp_on}, 3'b100);
    send_rx(8'h90);
    send_rx(8'h00);
    chk(done && end_status == 2'd1, "R8 end after out", end_status, 1);

    // R5/R7/R10: single acks, vpp, overrun
    base = tx_cnt;
    start_cmd(8'h30, 8'h03, 1'b1, 8'd1);
    send_rx(8'hCF);
    chk(!vpp_on, "R7 vpp idle one", vpp_on, 0);
    repeat (6) @(negedge clk);
    chk(tx_cnt == base + 6, "R5 one byte", tx_cnt - base, 6);
    send_rx(8'hCE);
    chk(vpp_on, "R7 vpp active one", vpp_on, 1);
    repeat (6) @(negedge clk);
    chk(tx_cnt == base + 7, "R5 second one", tx_cnt - base, 7);
    send_rx(8'h30);
    chk(!vpp_on, "R7 vpp back idle", vpp_on, 0);
    repeat (6) @(negedge clk);
    chk(tx_cnt == base + 8 && busy, "R4 remaining one", tx_cnt - base, 8);
    send_rx(8'h31);
    chk(done && end_status == 2'd3 && !vpp_on, "R10 overrun", {end_status, vpp_on}, 6);

    // R6/R4 incoming, R3 null mid-command
    start_cmd(8'h50, 8'h02, 1'b0, 8'd1);
    send_rx(8'h50);
    send_rx(8'h11);
    chk(rd_valid && rd_data == 8'h11, "R6 rd byte0", rd_data, 8'h11);
    send_rx(8'h12);
    chk(rd_valid && rd_data == 8'h12, "R6 rd byte1", rd_data, 8'h12);
    send_rx(8'h60);
    chk(busy && !done, "R3 null waits", done, 0);
    send_rx(8'h90);
    send_rx(8'h00);
    chk(done && end_status == 2'd1, "R4 in end", end_status, 1);

    // R11 invalid byte
    start_cmd(8'h50, 8'h01, 1'b0, 8'd1);
    send_rx(8'h13);
    chk(done && end_status == 2'd3, "R11 invalid", end_status, 3);

    // R3/R9 timeout restart by null, WI=1
    start_cmd(8'h40, 8'h00, 1'b0, 8'd1);
    repeat (900) @(negedge clk);
    chk(busy && !done, "R9 not yet expired", done, 0);
    send_rx(8'h60);
    k = 0;
    while (!done) begin @(negedge clk); k++; end
    chk(k == 960 * 1 * ETU + 1 && end_status == 2'd2, "R3 R9 timeout wi1", k, 960 * ETU + 1);

    // R9 default WI
    start_cmd(8'h40, 8'h00, 1'b0, 8'd0);
    send_rx(8'h60);
    k = 0;
    while (!done) begin @(negedge clk); k++; end
    chk(k == 960 * 10 * ETU + 1 && end_status == 2'd2, "R9 timeout default", k, 9600 * ETU + 1);

    // R2 sweep of every procedure byte value
    for (int v = 0; v < 256; v++) begin
      bit ok;
      int cls;
      ok  = 1'b1;
      cls = exp_class(8'(v), 8'hB2);
      start_cmd(8'hB2, 8'h01, 1'b0, 8'd1);
      send_rx(8'(v));
      case (cls)
        0: begin
          ok &= busy && !done;
          send_rx(8'h90);
          send_rx(8'h00);
          ok &= done && end_status == 2'd1;
        end
        1: begin
          ok &= busy && !done;
          send_rx(8'h55);
          ok &= done && end_status == 2'd1 && card_sw1 == 8'(v) && card_sw2 == 8'h55;
        end
        2, 3: begin
          ok &= busy && !done && (vpp_on == (v == 8'hB3 || v == 8'h4C));
          send_rx(8'h3C);
          ok &= rd_valid && rd_data == 8'h3C;
          send_rx(8'h90);
          send_rx(8'h00);
          ok &= done && end_status == 2'd1;
        end
        default: ok &= done && end_status == 2'd3;
      endcase
      chk(ok, "R2 class sweep", v, cls);
    end

    summary();
    $finish;
  end
endmodule